// File: doc/BRIEF.md
# Multicore External Interrupt Distributor

This block sits between a bank of external interrupt wires and a group of processor cores. Each distributed line is conditioned in one of two ways, chosen per line at build time. An edge line latches a rising edge into a pending flag that software acknowledges. A level line follows its synchronized input. The line then reaches a core only if its global enable is on and its routing mask selects that core. The block drives one interrupt vector per core. That vector feeds the core's own local controller.

Software controls the block through a single-cycle register port. Enables are never written directly. One address turns enable bits on and another turns them off, so two cores can change different lines without a read-modify-write race. Each line has its own routing word with one bit per core. The external input vector also carries the two lowest indices, which are reserved for inter-processor signalling. The block ignores them, so distributed line k is external input k+2.

Top module: `irq_dist`

## Requirements
- R1: After reset every enable bit is 0, every pending flag is 0, every routing word holds 1 (core 0 only), and all core outputs are 0.
- R2: A write to address 0x00 sets the enable of every line whose data bit is 1. Data bits that are 0 leave their enables unchanged. The write takes effect at the next clock edge.
- R3: A write to address 0x01 clears the enable of every line whose data bit is 1. Data bits that are 0 leave their enables unchanged.
- R4: Reads are combinational. Addresses 0x00 and 0x01 both return the enable vector in bits [NUM_LINES-1:0]. Address 0x02 returns the pending flags. Address 0x10+k returns line k's routing word in bits [NUM_CORES-1:0]. Unused bits read 0.
- R5: Output bit n*NUM_LINES+k (core n, line k) is 1 exactly when line k is active, its enable is 1, and bit n of its routing word is 1. A word with several bits set delivers the line to each selected core. An all-zero word delivers it to none.
- R6: Distributed line k is driven by input bit k+2. Input bits 0 and 1 have no effect on any output or readable state.
- R7: On an edge line (its EDGE_MASK bit is 1), a rising input edge sets the pending flag. The flag holds after the input falls, until a write to address 0x02 with a 1 in bit k. Zero bits in that write leave other flags set. The output appears within 3 clock edges of the input change.
- R8: A level line (its EDGE_MASK bit is 0) is active while its two-flop-synchronized input is high. It is never latched, and acknowledge writes do not affect it.
- R9: An edge is captured into the pending flag even while the line is disabled. Enabling the line later delivers it.
- R10: Writes to addresses outside the map change no state, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | NUM_LINES+2 | External interrupt inputs; bits 0 and 1 reserved |
| we_i | input | 1 | Write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data |
| irq_o | output | NUM_CORES*NUM_LINES | Per-core vectors, core n at [n*NUM_LINES +: NUM_LINES] |

## Verification
The bench sweeps every line against every one-hot route. This catches a design that swaps the core and line axes of the output, or drops the +2 offset and so answers to the reserved inputs. Edge lines are released before they are acknowledged. A design that passes edges through like levels would lose the interrupt at that point, and a design that latches level lines would keep it after release. Partial set, clear and acknowledge writes with mixed zero bits catch logic that overwrites whole registers instead of touching only the one bits. Edges that arrive while a line is disabled, multi-core and empty routes, and unmapped addresses round out the corner cases.

// File: rtl/irq_dist_pkg.sv
package irq_dist_pkg;
  localparam int unsigned EN_SET_ADDR  = 'h00;
  localparam int unsigned EN_CLR_ADDR  = 'h01;
  localparam int unsigned ACK_ADDR     = 'h02;
  localparam int unsigned ROUTE_BASE   = 'h10;
  localparam int unsigned RESERVED_LOW = 2;
endpackage

// File: rtl/irq_dist_capture.sv
module irq_dist_capture #(
  parameter int unsigned NUM_LINES = 8,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = '0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] line_i,
  input  logic [NUM_LINES-1:0] ack_i,
  output logic [NUM_LINES-1:0] active_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
    end
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
    if (EDGE_MASK[k]) begin : g_edge
      logic prev_q, pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          prev_q <= 1'b0;
          pend_q <= 1'b0;
        end else begin
          prev_q <= sync_q[k];
          // a fresh edge wins over a simultaneous acknowledge
          if (sync_q[k] && !prev_q)  pend_q <= 1'b1;
          else if (ack_i[k])         pend_q <= 1'b0;
        end
      end
      assign active_o[k] = pend_q;
      assign pend_o[k]   = pend_q;
    end else begin : g_level
      logic unused_ack;
      assign unused_ack  = ack_i[k];
      assign active_o[k] = sync_q[k];
      assign pend_o[k]   = 1'b0;
    end
  end
endmodule

// File: rtl/irq_dist_regs.sv
module irq_dist_regs
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [ADDR_W-1:0]                    addr_i,
  input  logic [DATA_W-1:0]                    wdata_i,
  input  logic [NUM_LINES-1:0]                 pend_i,
  output logic [DATA_W-1:0]                    rdata_o,
  output logic [NUM_LINES-1:0]                 en_o,
  output logic [NUM_LINES-1:0][NUM_CORES-1:0]  route_o,
  output logic [NUM_LINES-1:0]                 ack_o
);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(EN_SET_ADDR);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(EN_CLR_ADDR);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(ACK_ADDR);
  localparam logic [ADDR_W-1:0] A_RT   = ADDR_W'(ROUTE_BASE);
  localparam logic [ADDR_W-1:0] N_RT   = ADDR_W'(NUM_LINES);

  logic [NUM_LINES-1:0]                en_q;
  logic [NUM_LINES-1:0][NUM_CORES-1:0] route_q;
  logic [NUM_LINES-1:0]                wmask;
  logic [ADDR_W-1:0]                   rt_off;
  logic                                rt_hit;
  logic                                unused_wdata;

  assign wmask        = wdata_i[NUM_LINES-1:0];
  assign rt_off       = addr_i - A_RT;
  assign rt_hit       = (addr_i >= A_RT) && (rt_off < N_RT);
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= '0;
    end else if (we_i && addr_i == A_SET) begin
      en_q <= en_q | wmask;
    end else if (we_i && addr_i == A_CLR) begin
      en_q <= en_q & ~wmask;
    end
  end

  for (genvar k = 0; k < NUM_LINES; k++) begin : g_route
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        route_q[k] <= NUM_CORES'(1);
      else if (we_i && rt_hit && rt_off == ADDR_W'(k))
        route_q[k] <= wdata_i[NUM_CORES-1:0];
    end
  end

  assign ack_o = (we_i && addr_i == A_ACK) ? wmask : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_SET || addr_i == A_CLR) begin
      rdata_o[NUM_LINES-1:0] = en_q;
    end else if (addr_i == A_ACK) begin
      rdata_o[NUM_LINES-1:0] = pend_i;
    end else if (rt_hit) begin
      for (int k = 0; k < NUM_LINES; k++)
        if (rt_off == ADDR_W'(k)) rdata_o[NUM_CORES-1:0] = route_q[k];
    end
  end

  assign en_o    = en_q;
  assign route_o = route_q;
endmodule

// File: rtl/irq_dist_fanout.sv
module irq_dist_fanout #(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4
) (
  input  logic [NUM_LINES-1:0]                active_i,
  input  logic [NUM_LINES-1:0]                en_i,
  input  logic [NUM_LINES-1:0][NUM_CORES-1:0] route_i,
  output logic [NUM_CORES*NUM_LINES-1:0]      irq_o
);
  logic [NUM_LINES-1:0] gated;
  assign gated = active_i & en_i;

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
      assign irq_o[n*NUM_LINES+k] = gated[k] & route_i[k][n];
    end
  end
endmodule

// File: rtl/irq_dist.sv
module irq_dist
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter logic [NUM_LINES-1:0] EDGE_MASK = 8'h0F
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LINES+1:0]             ext_irq_i,
  input  logic                             we_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  output logic [DATA_W-1:0]                rdata_o,
  output logic [NUM_CORES*NUM_LINES-1:0]   irq_o
);
  localparam int unsigned EXT_W = NUM_LINES + RESERVED_LOW;

  logic [NUM_LINES-1:0]                line_in, active, pend, ack, en_q;
  logic [NUM_LINES-1:0][NUM_CORES-1:0] route_q;
  logic                                unused_ipi;

  // low indices carry inter-processor signals, handled elsewhere
  assign line_in    = ext_irq_i[EXT_W-1:RESERVED_LOW];
  assign unused_ipi = ^ext_irq_i[RESERVED_LOW-1:0];

  irq_dist_capture #(.NUM_LINES(NUM_LINES), .EDGE_MASK(EDGE_MASK)) u_capture (
    .clk_i, .rst_ni, .line_i(line_in), .ack_i(ack), .active_o(active), .pend_o(pend)
  );

  irq_dist_regs #(
    .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .pend_i(pend), .rdata_o,
    .en_o(en_q), .route_o(route_q), .ack_o(ack)
  );

  irq_dist_fanout #(.NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES)) u_fanout (
    .active_i(active), .en_i(en_q), .route_i(route_q), .irq_o
  );
endmodule

// File: rtl/irq_dist_chk.sv
module irq_dist_chk
  import irq_dist_pkg::*;
#(
  parameter int unsigned NUM_LINES = 8,
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32
) (
  input logic                           clk_i,
  input logic                           rst_ni,
  input logic                           we_i,
  input logic [ADDR_W-1:0]              addr_i,
  input logic [DATA_W-1:0]              wdata_i,
  input logic [NUM_LINES-1:0]           en_i,
  input logic [NUM_LINES-1:0]           pend_i,
  input logic [NUM_CORES*NUM_LINES-1:0] irq_i
);
  logic wr_set, wr_clr, wr_ack;
  logic [NUM_LINES-1:0] wm;
  assign wr_set = we_i && addr_i == ADDR_W'(EN_SET_ADDR);
  assign wr_clr = we_i && addr_i == ADDR_W'(EN_CLR_ADDR);
  assign wr_ack = we_i && addr_i == ADDR_W'(ACK_ADDR);
  assign wm     = wdata_i[NUM_LINES-1:0];

  assert_set_en_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> (en_i & $past(wm)) == $past(wm));

  assert_set_keep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> ((en_i ^ $past(en_i)) & ~$past(wm)) == '0);

  assert_clr_en_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (en_i & $past(wm)) == '0);

  assert_clr_keep_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((en_i ^ $past(en_i)) & ~$past(wm)) == '0);

  assert_pend_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ack |=> ($past(pend_i) & ~pend_i) == '0);

  for (genvar n = 0; n < NUM_CORES; n++) begin : g_core
    assert_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_i[n*NUM_LINES +: NUM_LINES] & ~en_i) == '0);
  end
endmodule

bind irq_dist irq_dist_chk #(
  .NUM_LINES(NUM_LINES), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .en_i(en_q), .pend_i(pend), .irq_i(irq_o)
);

// File: tb/tb_irq_dist.sv
module tb_irq_dist;
  import irq_dist_pkg::*;
  localparam int L = 8;
  localparam int C = 4;
  localparam logic [L-1:0] EDGE = 8'h0F;

  logic          clk = 0, rst_ni = 0, we = 0;
  logic [L+1:0]  ext = '0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0, rdata;
  logic [C*L-1:0] irq;

  int checks = 0, errors = 0;
  logic [L-1:0] en_m = '0, pend_m = '0, in_m = '0;
  logic [C-1:0] rt_m [L];

  always #5 clk = ~clk;

  irq_dist #(.NUM_LINES(L), .NUM_CORES(C), .EDGE_MASK(EDGE)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ext_irq_i(ext), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [C*L-1:0] model();
    logic [C*L-1:0] e = '0;
    for (int n = 0; n < C; n++)
      for (int k = 0; k < L; k++)
        e[n*L+k] = (EDGE[k] ? pend_m[k] : in_m[k]) & en_m[k] & rt_m[k][n];
    return e;
  endfunction

  task automatic settle(); repeat (4) @(negedge clk); endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    we = 1; addr = 8'(a); wdata = d;
    @(negedge clk);
    we = 0;
    if (a == EN_SET_ADDR) en_m |= d[L-1:0];
    else if (a == EN_CLR_ADDR) en_m &= ~d[L-1:0];
    else if (a == ACK_ADDR) pend_m &= ~d[L-1:0];
    else if (a >= ROUTE_BASE && a < ROUTE_BASE + L) rt_m[a-ROUTE_BASE] = d[C-1:0];
  endtask

  task automatic rd(int a, output logic [31:0] d);
    addr = 8'(a); #1; d = rdata;
  endtask

  task automatic drive(int k, logic v);
    if (EDGE[k] && v && !in_m[k]) pend_m[k] = 1'b1;
    in_m[k] = v;
    ext[k+2] = v;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    for (int k = 0; k < L; k++) rt_m[k] = 1;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd(EN_SET_ADDR, r); check("R1 enables", r, 0);
    rd(ACK_ADDR, r); check("R1 pending", r, 0);
    for (int k = 0; k < L; k++) begin rd(ROUTE_BASE + k, r); check("R1 route", r, 1); end

    // R2 / R4 set and readback at both addresses
    wr(EN_SET_ADDR, 32'h0000_00A5);
    rd(EN_SET_ADDR, r); check("R2 set", r, 32'hA5);
    wr(EN_SET_ADDR, 32'h0000_0042);
    rd(EN_CLR_ADDR, r); check("R2 zeros keep / R4 clr addr", r, 32'hE7);
    wr(EN_SET_ADDR, 32'h0);
    rd(EN_SET_ADDR, r); check("R2 zero write", r, 32'hE7);
    // R3 clear
    wr(EN_CLR_ADDR, 32'h0000_0081);
    rd(EN_SET_ADDR, r); check("R3 clear", r, 32'h66);
    wr(EN_CLR_ADDR, 32'h0);
    rd(EN_CLR_ADDR, r); check("R3 zero write", r, 32'h66);

    // R6 reserved inputs ignored
    wr(EN_SET_ADDR, 32'hFF);
    ext[1:0] = 2'b11; settle();
    check("R6 reserved high", 32'(irq), 0);
    rd(ACK_ADDR, r); check("R6 no pending", r, 0);
    ext[1:0] = 2'b00; settle();

    // R5 R7 R8 sweep over lines and one-hot routes
    for (int k = 0; k < L; k++) begin
      for (int n = 0; n < C; n++) begin
        wr(ROUTE_BASE + k, 32'(1 << n));
        rd(ROUTE_BASE + k, r); check("R4 route readback", r, 32'(1 << n));
        drive(k, 1);
        check("R5 deliver", 32'(irq), 32'(model()));
        if (!EDGE[k]) begin
          wr(ACK_ADDR, 32'(1 << k)); settle();
          check("R8 ack ignored", 32'(irq), 32'(model()));
        end
        drive(k, 0);
        check(EDGE[k] ? "R7 held" : "R8 follows", 32'(irq), 32'(model()));
        wr(ACK_ADDR, 32'(1 << k)); settle();
        check("R7 ack", 32'(irq), 0);
      end
      wr(ROUTE_BASE + k, 1);
    end

    // R5 multi-core and empty routes
    wr(ROUTE_BASE + 0, 32'hF);
    wr(ROUTE_BASE + 1, 32'h0);
    drive(0, 1); drive(1, 1);
    check("R5 multi/none", 32'(irq), 32'(model()));
    // R7 ack with zero bits keeps the other flag
    wr(ACK_ADDR, 32'h1); settle();
    check("R7 partial ack", 32'(irq), 32'(model()));
    rd(ACK_ADDR, r); check("R4 pending readback", r, 32'h2);
    drive(0, 0); drive(1, 0);
    wr(ACK_ADDR, 32'hFF); settle();

    // R9 capture while disabled
    wr(ROUTE_BASE + 2, 32'h4);
    wr(EN_CLR_ADDR, 32'h4);
    drive(2, 1); drive(2, 0);
    check("R9 disabled", 32'(irq), 0);
    wr(EN_SET_ADDR, 32'h4);
    check("R9 enabled later", 32'(irq), 32'(model()));
    wr(ACK_ADDR, 32'h4);

    // R10 unmapped
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, r); check("R10 unmapped read", r, 0);
    rd(EN_SET_ADDR, r); check("R10 enables intact", r, 32'(en_m));
    rd(ROUTE_BASE + L, r); check("R10 past routes", r, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule